// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a shift-based arithmetic engine built around three operand registers: an operand/divisor register (X), an upper accumulator (Y) and a lower accumulator (Z). The host first loads the registers through a simple write port. It then writes a control byte that can clear Y or Z and start an operation. A multiply forms X·Z, adds the previous Y to it, and leaves the double-width result split across Y (upper half) and Z (lower half). A divide treats Y:Z as a double-width dividend and divides it by X. The quotient goes to Z and the remainder to Y.

A divide leaves its remainder in Y, so the host can load the next lower word into Z and divide again. Chaining divides in this way divides a dividend of any length by a one-word divisor. The result of every step is ready after one start step plus WIDTH arithmetic steps. A control bit can slow the step rate with an internal divider. An overflow flag is captured on every control write and reports when a divide cannot produce a quotient that fits.

Top module: `muldiv_unit`

## Requirements
- R1: A multiply leaves Y:Z = X·Z + Y (Y and Z taken after any control-byte clears). Y holds the upper WIDTH bits and Z the lower WIDTH bits. X is unchanged.
- R2: A divide with Y < X leaves the quotient of Y:Z ÷ X in Z and the remainder in Y, and X is unchanged. A remainder left in Y can be chained with a new Z word to extend the dividend.
- R3: Writing the control byte with bit 3 set clears Y, and with bit 2 set clears Z. The clear takes effect in the write cycle, before any operation, and it also applies when no operation is started.
- R4: Control bits 1:0 select the operation: 01 multiply, 10 divide, 00 and 11 start nothing. busy rises on the cycle after a multiply or divide is written and stays low for the other two codes.
- R5: At full rate, busy stays high for exactly WIDTH+1 clock cycles. When busy drops, control bits 1:0 read back as 00.
- R6: When control bit 7 is set, each step waits SLOW_DIV clock cycles. busy then lasts (WIDTH+1)·SLOW_DIV cycles, and the results are the same as at full rate.
- R7: Each accepted control write sets ovf to 1 exactly when the effective Y (after a bit-3 clear) is greater than or equal to X, which includes X = 0. ovf holds its value until the next accepted control write.
- R8: Raising clr for one cycle stops a running operation. busy reads low on the next cycle, and control bits 1:0 read 00.
- R9: While busy is high, writes to every register (control byte included) are ignored. Reads return the current register contents.
- R10: wr_sel and rd_sel address 0 = X, 1 = Y, 2 = Z, 3 = control byte. The control byte sits in data bits 7:0 and reads back zero-extended.
- R11: After reset, X, Y, Z and the control byte read 0, and busy and ovf are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the sequencer, divider and operation bits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 X, 1 Y, 2 Z, 3 control |
| wr_data | input | WIDTH | Write data (control byte in bits 7:0) |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | WIDTH | Selected register contents |
| busy | output | 1 | Operation in progress |
| ovf | output | 1 | Divide overflow flag captured at the last control write |

## Verification
The hardest conditions to reach from the ports are the overflow boundary, where Y is exactly X−1 against exactly X, and a multi-word dividend carried through chained divides, where each remainder must feed the next step without being reloaded. The stimulus builds these cases directly: Y and X are written one apart, and a three-word dividend is split into words and divided in sequence. The bench then compares the joined quotient against a wide division computed in the bench. Seeded random multiplies and divides follow, some at the slow step rate, together with write attempts and a clear while an operation is running.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    SEL_X    = 2'd0,
    SEL_Y    = 2'd1,
    SEL_Z    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_MUL  = 2'b01,
    OP_DIV  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  // control byte: [7] slow rate, [6:4] spare, [3] clear Y, [2] clear Z, [1:0] op
  typedef struct packed {
    logic       slow;
    logic [2:0] spare;
    logic       yclr;
    logic       zclr;
    op_e        op;
  } ctrl_t;

  localparam int CTRL_BITS = 8;

endpackage

// File: rtl/muldiv_tick.sv
module muldiv_tick #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (!slow) begin
      tick = 1'b1;
    end else if (cnt_q == LAST) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (SLOW_DIV > 1) begin : g_gap_chk
      // R6: in slow mode two step ticks are never adjacent
      a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slow) |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/muldiv_ctl.sv
module muldiv_ctl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_byte,
  input  logic       tick,
  output ctrl_t      ctrl_q,
  output logic       busy,
  output logic       step_en
);
  localparam int SW = $clog2(WIDTH + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(WIDTH);

  ctrl_t         ctrl_d;
  logic [SW-1:0] step_q, step_d;

  assign busy = (ctrl_q.op == OP_MUL) || (ctrl_q.op == OP_DIV);

  always_comb begin
    ctrl_d  = ctrl_q;
    step_d  = step_q;
    step_en = 1'b0;
    if (clr) begin
      ctrl_d.op = OP_IDLE;
      step_d    = '0;
    end else if (wr_ctrl) begin
      ctrl_d = ctrl_t'(wr_byte);
      step_d = '0;
    end else if (busy && tick) begin
      if (step_q == LAST_STEP) begin
        ctrl_d.op = OP_IDLE;
        step_d    = '0;
      end else begin
        step_en = 1'b1;
        step_d  = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      step_q <= step_d;
    end
  end

  // R5: step counter never runs past the final step
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  // R5: a normal finish happens only from the last step
  a_r5_finish_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(clr)) |-> ($past(step_q) == LAST_STEP));
  // R4: a multiply or divide code starts an operation
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !clr && (wr_byte[1:0] == 2'b01 || wr_byte[1:0] == 2'b10)) |=> busy);
  // R8: clear stops the operation
  a_r8_clr_stop: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy);

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int WIDTH = 16
) (
  input  logic             is_div,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] z,
  output logic [WIDTH-1:0] y_nx,
  output logic [WIDTH-1:0] z_nx
);
  logic [WIDTH:0] sum;
  logic [WIDTH:0] rem;
  logic [WIDTH:0] diff;
  logic           ge;

  always_comb begin
    // shift-add: conditionally add X into Y, shift carry:Y:Z right
    sum = {1'b0, y} + (z[0] ? {1'b0, x} : '0);
    // restoring divide: shift Y:Z left, trial subtract X
    rem  = {y, z[WIDTH-1]};
    diff = rem - {1'b0, x};
    ge   = (rem >= {1'b0, x});
    if (is_div) begin
      y_nx = ge ? diff[WIDTH-1:0] : rem[WIDTH-1:0];
      z_nx = {z[WIDTH-2:0], ge};
    end else begin
      y_nx = sum[WIDTH:1];
      z_nx = {sum[0], z[WIDTH-1:1]};
    end
  end

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             step_en,
  input  logic             is_div,
  input  logic             busy,
  output logic [WIDTH-1:0] x_q,
  output logic [WIDTH-1:0] y_q,
  output logic [WIDTH-1:0] z_q,
  output logic             ovf_q
);
  logic [WIDTH-1:0] x_d, y_d, z_d, y_nx, z_nx, y_eff;
  logic             ovf_d;
  ctrl_t            wr_ctrl;

  assign wr_ctrl = ctrl_t'(wr_data[CTRL_BITS-1:0]);

  muldiv_step #(.WIDTH(WIDTH)) u_step (
    .is_div(is_div),
    .x     (x_q),
    .y     (y_q),
    .z     (z_q),
    .y_nx  (y_nx),
    .z_nx  (z_nx)
  );

  always_comb begin
    x_d   = x_q;
    y_d   = y_q;
    z_d   = z_q;
    ovf_d = ovf_q;
    y_eff = wr_ctrl.yclr ? '0 : y_q;
    if (wr_ok) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_X: x_d = wr_data;
        SEL_Y: y_d = wr_data;
        SEL_Z: z_d = wr_data;
        SEL_CTRL: begin
          y_d   = y_eff;
          if (wr_ctrl.zclr) z_d = '0;
          ovf_d = (y_eff >= x_q);
        end
        default: ;
      endcase
    end else if (step_en) begin
      y_d = y_nx;
      z_d = z_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      ovf_q <= 1'b0;
    end else begin
      x_q   <= x_d;
      y_q   <= y_d;
      z_q   <= z_d;
      ovf_q <= ovf_d;
    end
  end

  // R9: X is never written while an operation runs
  a_r9_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q));
  // R7: overflow flag holds while an operation runs
  a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ovf_q));
  // R9: no register write is accepted while busy
  a_r9_no_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ok);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             busy,
  output logic             ovf
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             wr_ok, wr_ctrl, tick, step_en;
  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] x_q, y_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign wr_ok   = wr_en && !busy && !clr;
  assign wr_ctrl = wr_ok && (reg_sel_e'(wr_sel) == SEL_CTRL);

  muldiv_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (clr),
    .run  (busy),
    .slow (ctrl_q.slow),
    .tick (tick)
  );

  muldiv_ctl #(.WIDTH(WIDTH)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .wr_ctrl(wr_ctrl),
    .wr_byte(wr_data[CTRL_BITS-1:0]),
    .tick   (tick),
    .ctrl_q (ctrl_q),
    .busy   (busy),
    .step_en(step_en)
  );

  muldiv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_ok  (wr_ok),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .step_en(step_en),
    .is_div (ctrl_q.op == OP_DIV),
    .busy   (busy),
    .x_q    (x_q),
    .y_q    (y_q),
    .z_q    (z_q),
    .ovf_q  (ovf)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_X:    rd_data = x_q;
      SEL_Y:    rd_data = y_q;
      SEL_Z:    rd_data = z_q;
      default:  rd_data = {{(WIDTH-CTRL_BITS){1'b0}}, ctrl_q};
    endcase
  end

  // R4: reserved and idle codes never leave busy set
  a_r4_idle_codes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_ctrl && (wr_data[1:0] == 2'b00 || wr_data[1:0] == 2'b11)) |=> !busy);

endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam int W  = 16;
  localparam int PD = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = 2'd0;
  logic [W-1:0] rd_data;
  logic         busy, ovf;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc;
  logic [W-1:0] rv;
  longint unsigned xa, ya, za, ex, dd, q_all, r_prev;

  always #4 clk = ~clk;

  muldiv_unit #(.WIDTH(W), .SLOW_DIV(PD)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .ovf(ovf)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic go(input logic [7:0] cb, output int n);
    wr(2'd3, W'(cb));
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic longint unsigned f_mul(longint unsigned x, longint unsigned y, longint unsigned z);
    return x * z + y;
  endfunction

  task automatic load(input longint unsigned x, input longint unsigned y, input longint unsigned z);
    wr(2'd0, W'(x)); wr(2'd1, W'(y)); wr(2'd2, W'(z));
  endtask

  task automatic chk_yz(input string req, input longint unsigned hi, input longint unsigned lo);
    logic [W-1:0] v;
    rd(2'd1, v); chk(req, v, hi & 64'hFFFF);
    rd(2'd2, v); chk(req, v, lo & 64'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(2'd0, rv); chk("R11 X", rv, 0);
    rd(2'd1, rv); chk("R11 Y", rv, 0);
    rd(2'd2, rv); chk("R11 Z", rv, 0);
    rd(2'd3, rv); chk("R11 ctrl", rv, 0);
    chk("R11 busy", busy, 0);
    chk("R11 ovf", ovf, 0);

    // R10 register addressing
    load(64'h1234, 64'h0042, 64'hBEEF);
    rd(2'd0, rv); chk("R10 X", rv, 64'h1234);
    rd(2'd1, rv); chk("R10 Y", rv, 64'h0042);
    rd(2'd2, rv); chk("R10 Z", rv, 64'hBEEF);

    // R1 + R5 worst-case multiply-accumulate
    load(64'hFFFF, 64'hFFFF, 64'hFFFF);
    go(8'h01, cyc);
    chk("R5 busy cycles", cyc, W + 1);
    ex = f_mul(64'hFFFF, 64'hFFFF, 64'hFFFF);
    chk_yz("R1 max mul", ex >> W, ex);
    rd(2'd0, rv); chk("R1 X kept", rv, 64'hFFFF);
    rd(2'd3, rv); chk("R5 op bits cleared", rv & 3, 0);

    // R3 clear Y with multiply
    load(3, 7, 5);
    go(8'h09, cyc);
    chk_yz("R3 yclr mul", 0, 15);

    // R3 + R4 reserved code clears both, starts nothing
    load(9, 64'hAAAA, 64'h5555);
    go(8'h0F, cyc);
    chk("R4 rsvd no busy", cyc, 0);
    chk_yz("R3 both clr", 0, 0);
    load(9, 64'hAAAA, 64'h5555);
    go(8'h04, cyc);
    chk("R4 idle no busy", cyc, 0);
    chk_yz("R3 zclr only", 64'hAAAA, 0);
    go(8'h00, cyc);
    chk_yz("R4 idle no change", 64'hAAAA, 0);

    // R2 chained divide of a three-word dividend
    dd = 64'h00A7_5C31_9E02;
    wr(2'd0, W'(64'h03F1));
    wr(2'd2, W'(dd >> 32));
    go(8'h0A, cyc);
    chk("R7 chain1 ovf", ovf, 0);
    rd(2'd2, rv); q_all = rv;
    wr(2'd2, W'(dd >> 16));
    go(8'h02, cyc);
    chk("R7 chain2 ovf", ovf, 0);
    rd(2'd2, rv); q_all = (q_all << 16) | rv;
    wr(2'd2, W'(dd));
    go(8'h02, cyc);
    rd(2'd2, rv); q_all = (q_all << 16) | rv;
    chk("R2 chained quotient", q_all, dd / 64'h03F1);
    rd(2'd1, rv); chk("R2 chained remainder", rv, dd % 64'h03F1);
    rd(2'd0, rv); chk("R2 X kept", rv, 64'h03F1);

    // R7 overflow boundary
    load(5, 4, 0); go(8'h00, cyc); chk("R7 Y=X-1", ovf, 0);
    wr(2'd1, 5);   go(8'h00, cyc); chk("R7 Y=X", ovf, 1);
    wr(2'd0, 6);                   chk("R7 hold on X write", ovf, 1);
    load(0, 0, 0); go(8'h00, cyc); chk("R7 div by zero", ovf, 1);
    load(1, 9, 0); go(8'h08, cyc); chk("R7 effective Y", ovf, 0);

    // R6 slow rate multiply
    load(64'h1357, 64'h0F0F, 64'hABCD);
    go(8'h81, cyc);
    chk("R6 slow cycles", cyc, (W + 1) * PD);
    ex = f_mul(64'h1357, 64'h0F0F, 64'hABCD);
    chk_yz("R6 slow mul", ex >> W, ex);

    // R9 writes ignored while busy, reads live
    load(64'h0123, 64'h0045, 64'h6789);
    wr(2'd3, W'(8'h82));
    chk("R9 busy up", busy, 1);
    wr(2'd0, 0);
    wr(2'd1, 64'hFFFF);
    wr(2'd2, 64'hFFFF);
    wr(2'd3, W'(8'h0D));
    rd(2'd0, rv); chk("R9 X read during busy", rv, 64'h0123);
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
    dd = (64'h0045 << 16) | 64'h6789;
    chk_yz("R9 div unaffected", dd % 64'h0123, dd / 64'h0123);
    rd(2'd0, rv); chk("R9 X after", rv, 64'h0123);

    // R8 clear mid operation
    load(64'h00FF, 0, 64'h00FF);
    wr(2'd3, W'(8'h81));
    repeat (10) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 busy low", busy, 0);
    rd(2'd3, rv); chk("R8 op bits", rv & 3, 0);

    // random mix (R1, R2, R5, R6)
    for (int i = 0; i < 40; i++) begin
      logic slow_sel, do_div;
      logic [7:0] cb;
      slow_sel = ($urandom % 4) == 0;
      do_div   = $urandom % 2;
      xa = $urandom & 64'hFFFF;
      za = $urandom & 64'hFFFF;
      if (do_div) begin
        if (xa == 0) xa = 1;
        ya = ($urandom & 64'hFFFF) % xa;
      end else begin
        ya = $urandom & 64'hFFFF;
      end
      load(xa, ya, za);
      cb = {slow_sel, 5'b0, do_div, !do_div};
      go(cb, cyc);
      chk(slow_sel ? "R6 rand cycles" : "R5 rand cycles", cyc, slow_sel ? (W + 1) * PD : W + 1);
      if (do_div) begin
        dd = (ya << 16) | za;
        chk_yz("R2 rand div", dd % xa, dd / xa);
      end else begin
        ex = f_mul(xa, ya, za);
        chk_yz("R1 rand mul", ex >> W, ex);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule